// File: doc/BRIEF.md
# Multiply-Divide Unit with HI/LO Result Pair

This block carries out 32-bit integer multiplication and division for a processor datapath. The result goes into a private pair of registers, HI and LO, and is not returned directly. A caller presents a function code, two operands and a one-cycle `start` strobe. Multiply and divide then run iteratively and retire one bit per cycle. A multiply leaves the 64-bit product split across HI (upper half) and LO (lower half). A divide leaves the quotient in LO and the remainder in HI. Division by zero raises no error: it clears both registers.

Four more function codes move data between HI/LO and the rest of the datapath. Move-to codes copy `op_a` into HI or LO. Move-from codes return HI or LO on `rd_data`, qualified by `rd_valid`. If a move-from arrives while an operation is running, it is held as a single pending read. That read is answered only after the result has been written, so a half-finished result is never returned.

Control is a three-state machine in the arithmetic core:
- IDLE → RUN when an arithmetic start is accepted.
- RUN → RUN while the iteration count is below 31.
- RUN → FIN on the last iteration.
- FIN → IDLE unconditionally.

A separate pending-read flag is set when a move-from arrives during RUN or FIN. It is cleared on the first cycle the core is back in IDLE, and that cycle services the read. `busy` is high whenever the core is outside IDLE or a read is pending.

Top module: `muldiv_hilo`

## Requirements
- R1: After reset, HI and LO are zero, and `busy`, `done`, `invalid` and `rd_valid` are low.
- R2: The function code values are as follows; every other value is invalid.
  - 0x18 is a signed multiply; 0x19 is an unsigned multiply.
  - 0x1A is a signed divide; 0x1B is an unsigned divide.
  - 0x10 reads HI; 0x11 writes HI; 0x12 reads LO; 0x13 writes LO.
- R3: A multiply leaves product bits 63:32 in HI and bits 31:0 in LO. The signed form sign-extends both operands to 64 bits; the unsigned form zero-extends them.
- R4: A divide leaves the quotient in LO and the remainder in HI. The signed form truncates toward zero, and the remainder carries the sign of the dividend. 0x80000000 divided by -1 gives quotient 0x80000000 and remainder 0.
- R5: A divide by zero, signed or unsigned, sets both HI and LO to zero and does not raise `invalid`.
- R6: Timing of an accepted arithmetic start:
  - `busy` is high from the next cycle for exactly 33 cycles.
  - `done` is high only in the 33rd of those cycles.
  - HI/LO hold the new result from the cycle after `done`.
- R7: A `start` seen while `busy` is high has no arithmetic or move-to effect, and HI/LO keep the running operation's result.
- R8: A move-to accepted while idle loads `op_a` into the chosen register and leaves the other unchanged. A move-from accepted while idle raises `rd_valid` for one cycle, in the next cycle, with the register value on `rd_data`.
- R9: A move-from seen during an operation does not answer at once. It is answered two cycles after `done` with the new result, and `busy` stays high until that answer.
- R10: An invalid function code accepted while idle raises `invalid` for one cycle, in the next cycle, and leaves HI and LO unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe; taken only when `busy` is low |
| func | input | 6 | Function code (see R2) |
| op_a | input | 32 | First operand / dividend / move-to data |
| op_b | input | 32 | Second operand / divisor |
| busy | output | 1 | Operation running or read pending |
| done | output | 1 | One-cycle pulse in the last busy cycle of an operation |
| invalid | output | 1 | One-cycle pulse after an unsupported code |
| rd_valid | output | 1 | Move-from data valid on `rd_data` |
| rd_data | output | 32 | HI or LO contents for a move-from |

## Verification
The signed corner cases need the most care.
- A divide whose dividend and divisor have opposite signs, and one with a negative dividend, catch a design that floors instead of truncating, or that gives the remainder the divisor's sign.
- Overflow division (most-negative by -1) and squaring the most negative number catch a magnitude path that is one bit too narrow.
- Both divide-by-zero forms are checked for zero results and no `invalid` pulse; a design that skipped the special case would leave all-ones in LO.

The busy-window cases probe the handshake.
- A move-to and a second divide are issued during a multiply. A design that accepted either would corrupt HI or LO.
- A move-from is issued during a multiply. A design that answered it early would return the stale value.
- The exact 33-cycle busy count catches an off-by-one iteration counter.

Random operands, a share of them zero or small divisors, are compared against a 64-bit reference.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

    localparam logic [5:0] FN_RD_HI = 6'h10;
    localparam logic [5:0] FN_WR_HI = 6'h11;
    localparam logic [5:0] FN_RD_LO = 6'h12;
    localparam logic [5:0] FN_WR_LO = 6'h13;
    localparam logic [5:0] FN_MUL_S = 6'h18;
    localparam logic [5:0] FN_MUL_U = 6'h19;
    localparam logic [5:0] FN_DIV_S = 6'h1A;
    localparam logic [5:0] FN_DIV_U = 6'h1B;

    typedef enum logic [2:0] {
        K_NONE,
        K_MUL,
        K_DIV,
        K_RDHI,
        K_WRHI,
        K_RDLO,
        K_WRLO
    } kind_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_RUN,
        S_FIN
    } core_st_e;

endpackage

// File: rtl/muldiv_decode.sv
module muldiv_decode
    import muldiv_pkg::*;
(
    input  logic [5:0] func,
    output kind_e      kind,
    output logic       sgn
);

    // R2: function code classification
    always_comb begin
        kind = K_NONE;
        sgn  = 1'b0;
        unique case (func)
            FN_MUL_S: begin kind = K_MUL; sgn = 1'b1; end
            FN_MUL_U: kind = K_MUL;
            FN_DIV_S: begin kind = K_DIV; sgn = 1'b1; end
            FN_DIV_U: kind = K_DIV;
            FN_RD_HI: kind = K_RDHI;
            FN_WR_HI: kind = K_WRHI;
            FN_RD_LO: kind = K_RDLO;
            FN_WR_LO: kind = K_WRLO;
            default:  kind = K_NONE;
        endcase
    end

endmodule

// File: rtl/muldiv_core.sv
module muldiv_core
    import muldiv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic         is_div,
    input  logic         sgn,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] res_hi,
    output logic [W-1:0] res_lo
);

    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    core_st_e       st, st_nx;
    logic [CW-1:0]  cnt;
    logic [W-1:0]   acc_hi, acc_lo, dsr;
    logic           op_div, neg_main, neg_rem, by_zero;

    logic [W-1:0]   a_mag, b_mag;
    logic [W:0]     m_sum, d_try;
    logic           d_ge;
    logic [W-1:0]   d_diff;
    logic [W-1:0]   step_hi, step_lo;
    logic [2*W-1:0] prod, prod_fix;

    assign a_mag = (sgn && a[W-1]) ? (~a + 1'b1) : a;
    assign b_mag = (sgn && b[W-1]) ? (~b + 1'b1) : b;

    // one iteration: shift-add for multiply, restoring step for divide
    always_comb begin
        m_sum  = {1'b0, acc_hi} + (acc_lo[0] ? {1'b0, dsr} : {(W+1){1'b0}});
        d_try  = {acc_hi, acc_lo[W-1]};
        d_ge   = d_try >= {1'b0, dsr};
        d_diff = d_try[W-1:0] - dsr;
        if (op_div) begin
            step_hi = d_ge ? d_diff : d_try[W-1:0];
            step_lo = {acc_lo[W-2:0], d_ge};
        end else begin
            step_hi = m_sum[W:1];
            step_lo = {m_sum[0], acc_lo[W-1:1]};
        end
    end

    // next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE:  if (go) st_nx = S_RUN;
            S_RUN:   if (cnt == LAST) st_nx = S_FIN;
            S_FIN:   st_nx = S_IDLE;
            default: st_nx = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            acc_hi   <= '0;
            acc_lo   <= '0;
            dsr      <= '0;
            op_div   <= 1'b0;
            neg_main <= 1'b0;
            neg_rem  <= 1'b0;
            by_zero  <= 1'b0;
        end else if (st == S_IDLE && go) begin
            cnt      <= '0;
            acc_hi   <= '0;
            acc_lo   <= a_mag;
            dsr      <= b_mag;
            op_div   <= is_div;
            neg_main <= sgn && (a[W-1] ^ b[W-1]);
            neg_rem  <= sgn && a[W-1];
            by_zero  <= is_div && (b == '0);
        end else if (st == S_RUN) begin
            cnt    <= cnt + 1'b1;
            acc_hi <= step_hi;
            acc_lo <= step_lo;
        end
    end

    // outputs
    always_comb begin
        prod     = {acc_hi, acc_lo};
        prod_fix = neg_main ? (~prod + 1'b1) : prod;
        busy     = 1'b0;
        done     = 1'b0;
        unique case (st)
            S_IDLE:  busy = 1'b0;
            S_RUN:   busy = 1'b1;
            S_FIN:   begin busy = 1'b1; done = 1'b1; end
            default: busy = 1'b0;
        endcase
        if (by_zero) begin
            res_hi = '0;
            res_lo = '0;
        end else if (op_div) begin
            res_hi = neg_rem  ? (~acc_hi + 1'b1) : acc_hi;
            res_lo = neg_main ? (~acc_lo + 1'b1) : acc_lo;
        end else begin
            res_hi = prod_fix[2*W-1:W];
            res_lo = prod_fix[W-1:0];
        end
    end

    a_r6_busy_after_go: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> busy);
    a_r6_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r7_go_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !busy);

endmodule

// File: rtl/muldiv_hilo_regs.sv
module muldiv_hilo_regs #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld_arith,
    input  logic [W-1:0] arith_hi,
    input  logic [W-1:0] arith_lo,
    input  logic         wr_hi,
    input  logic         wr_lo,
    input  logic [W-1:0] wr_data,
    input  logic         rd_req,
    input  logic         rd_hi,
    output logic         rd_valid,
    output logic [W-1:0] rd_data
);

    logic [W-1:0] hi_q, lo_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (ld_arith) begin
            hi_q <= arith_hi;
            lo_q <= arith_lo;
        end else begin
            if (wr_hi) hi_q <= wr_data;
            if (wr_lo) lo_q <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_req;
            if (rd_req) rd_data <= rd_hi ? hi_q : lo_q;
        end
    end

    a_r8_hold_unwritten: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_arith || wr_hi || wr_lo) |=> ($stable(hi_q) && $stable(lo_q)));
    a_r8_read_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_req));

endmodule

// File: rtl/muldiv_hilo.sv
module muldiv_hilo
    import muldiv_pkg::*;
#(
    parameter int W  = 32,
    parameter int FW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [FW-1:0] func,
    input  logic [W-1:0]  op_a,
    input  logic [W-1:0]  op_b,
    output logic          busy,
    output logic          done,
    output logic          invalid,
    output logic          rd_valid,
    output logic [W-1:0]  rd_data
);

    kind_e        kind;
    logic         sgn, core_busy, accept, go, is_rd, rd_req, rd_hi;
    logic         pend_q, pend_hi_q, invalid_q;
    logic [W-1:0] res_hi, res_lo;

    muldiv_decode u_dec (
        .func (func),
        .kind (kind),
        .sgn  (sgn)
    );

    assign busy   = core_busy || pend_q;
    assign accept = start && !busy;
    assign go     = accept && (kind == K_MUL || kind == K_DIV);
    assign is_rd  = (kind == K_RDHI) || (kind == K_RDLO);
    assign rd_req = (accept && is_rd) || (pend_q && !core_busy);
    assign rd_hi  = pend_q ? pend_hi_q : (kind == K_RDHI);

    muldiv_core #(.W(W)) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (go),
        .is_div (kind == K_DIV),
        .sgn    (sgn),
        .a      (op_a),
        .b      (op_b),
        .busy   (core_busy),
        .done   (done),
        .res_hi (res_hi),
        .res_lo (res_lo)
    );

    muldiv_hilo_regs #(.W(W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_arith (done),
        .arith_hi (res_hi),
        .arith_lo (res_lo),
        .wr_hi    (accept && kind == K_WRHI),
        .wr_lo    (accept && kind == K_WRLO),
        .wr_data  (op_a),
        .rd_req   (rd_req),
        .rd_hi    (rd_hi),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    // R9: one held read while the core runs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q    <= 1'b0;
            pend_hi_q <= 1'b0;
        end else if (pend_q && !core_busy) begin
            pend_q <= 1'b0;
        end else if (start && core_busy && !pend_q && is_rd) begin
            pend_q    <= 1'b1;
            pend_hi_q <= (kind == K_RDHI);
        end
    end

    // R10: invalid code pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) invalid_q <= 1'b0;
        else        invalid_q <= accept && (kind == K_NONE);
    end
    assign invalid = invalid_q;

    a_r10_invalid_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        invalid |-> $past(start && !busy));
    a_r9_no_partial_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(!core_busy));

endmodule

// File: tb/sim_muldiv_hilo.sv
module sim_muldiv_hilo;

    localparam logic [5:0] RDHI = 6'h10, WRHI = 6'h11, RDLO = 6'h12, WRLO = 6'h13;
    localparam logic [5:0] MULS = 6'h18, MULU = 6'h19, DIVS = 6'h1A, DIVU = 6'h1B;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [5:0]  func = '0;
    logic [31:0] op_a = '0, op_b = '0;
    logic        busy, done, invalid, rd_valid;
    logic [31:0] rd_data;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [31:0] m_hi = '0, m_lo = '0;

    always #4 clk = ~clk;

    muldiv_hilo u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .func(func),
        .op_a(op_a), .op_b(op_b), .busy(busy), .done(done),
        .invalid(invalid), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL watchdog: act=%0d exp<=100000 cycles", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] model(input logic [5:0] f, input logic [31:0] x,
                                          input logic [31:0] y);
        logic signed [63:0] sx, sy, q, r;
        sx = {{32{x[31]}}, x};
        sy = {{32{y[31]}}, y};
        case (f)
            MULS: model = sx * sy;
            MULU: model = {32'b0, x} * {32'b0, y};
            DIVS: begin
                if (y == 0) model = '0;
                else begin
                    q = sx / sy;
                    r = sx % sy;
                    model = {r[31:0], q[31:0]};
                end
            end
            DIVU: model = (y == 0) ? 64'd0 : {x % y, x / y};
            default: model = {m_hi, m_lo};
        endcase
    endfunction

    task automatic do_start(input logic [5:0] f, input logic [31:0] x, input logic [31:0] y);
        start = 1'b1; func = f; op_a = x; op_b = y;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic read_reg(input logic hi, input string tag, output logic [31:0] v);
        do_start(hi ? RDHI : RDLO, 32'h0, 32'h0);
        chk({tag, " rd_valid"}, {31'b0, rd_valid}, 32'd1);
        v = rd_data;
    endtask

    task automatic wait_done(output int n);
        n = 1;
        while (!done && n < 200) begin
            @(negedge clk);
            n = n + 1;
        end
    endtask

    task automatic arith(input logic [5:0] f, input logic [31:0] x, input logic [31:0] y,
                         input string tag);
        logic [63:0] e;
        logic [31:0] v;
        int n;
        e = model(f, x, y);
        do_start(f, x, y);
        chk("R6 busy after start", {31'b0, busy}, 32'd1);
        chk("R5 no invalid", {31'b0, invalid}, 32'd0);
        wait_done(n);
        chk("R6 done cycle", n, 32'd33);
        @(negedge clk);
        chk("R6 busy low after done", {31'b0, busy}, 32'd0);
        m_hi = e[63:32];
        m_lo = e[31:0];
        read_reg(1'b1, tag, v);
        chk({tag, " HI"}, v, m_hi);
        read_reg(1'b0, tag, v);
        chk({tag, " LO"}, v, m_lo);
    endtask

    initial begin
        logic [31:0] v;
        int n;
        logic [31:0] seed_v;
        seed_v = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 busy", {31'b0, busy}, 32'd0);
        chk("R1 done", {31'b0, done}, 32'd0);
        chk("R1 invalid", {31'b0, invalid}, 32'd0);
        chk("R1 rd_valid", {31'b0, rd_valid}, 32'd0);
        read_reg(1'b1, "R1", v); chk("R1 HI zero", v, 32'd0);
        read_reg(1'b0, "R1", v); chk("R1 LO zero", v, 32'd0);

        // R8 move-to / move-from, R2 codes
        do_start(WRHI, 32'h12345678, 32'h0);
        do_start(WRLO, 32'h9abcdef0, 32'h0);
        read_reg(1'b1, "R8", v); chk("R8 HI write", v, 32'h12345678);
        read_reg(1'b0, "R8", v); chk("R8 LO write", v, 32'h9abcdef0);
        m_hi = 32'h12345678; m_lo = 32'h9abcdef0;

        // R10 invalid codes
        do_start(6'h05, 32'hffffffff, 32'h1);
        chk("R10 invalid pulse", {31'b0, invalid}, 32'd1);
        @(negedge clk);
        chk("R10 invalid one cycle", {31'b0, invalid}, 32'd0);
        do_start(6'h1C, 32'h7, 32'h3);
        chk("R10 invalid 0x1C", {31'b0, invalid}, 32'd1);
        chk("R10 not busy", {31'b0, busy}, 32'd0);
        read_reg(1'b1, "R10", v); chk("R10 HI kept", v, m_hi);
        read_reg(1'b0, "R10", v); chk("R10 LO kept", v, m_lo);

        // R3 / R4 / R5 directed corners
        arith(MULS, 32'd5, 32'hfffffffc, "R3 mul signed");
        arith(MULU, 32'd5, 32'hfffffffc, "R3 mul unsigned");
        arith(MULS, 32'h80000000, 32'h80000000, "R3 mul minneg");
        arith(MULU, 32'hffffffff, 32'hffffffff, "R3 mul max");
        arith(DIVS, 32'd5, 32'hfffffffc, "R4 div signed");
        arith(DIVS, 32'hfffffff9, 32'd2, "R4 div neg dividend");
        arith(DIVS, 32'h80000000, 32'hffffffff, "R4 div overflow");
        arith(DIVU, 32'd5, 32'hfffffffc, "R4 div unsigned");
        arith(DIVU, 32'hdeadbeef, 32'd0, "R5 divu zero");
        arith(DIVS, 32'h80000001, 32'd0, "R5 div zero");

        // R7 starts during busy are ignored
        do_start(MULU, 32'd3, 32'd4);
        do_start(WRHI, 32'hdead0000, 32'h0);
        do_start(DIVS, 32'd100, 32'd7);
        wait_done(n);
        @(negedge clk);
        read_reg(1'b1, "R7", v); chk("R7 HI after ignored", v, 32'd0);
        read_reg(1'b0, "R7", v); chk("R7 LO after ignored", v, 32'd12);
        m_hi = 32'd0; m_lo = 32'd12;

        // R9 move-from while busy
        do_start(MULU, 32'h00010000, 32'h00030003);
        do_start(RDLO, 32'h0, 32'h0);
        chk("R9 no early read", {31'b0, rd_valid}, 32'd0);
        wait_done(n);
        @(negedge clk);
        chk("R9 busy during service", {31'b0, busy}, 32'd1);
        chk("R9 not yet valid", {31'b0, rd_valid}, 32'd0);
        @(negedge clk);
        chk("R9 read valid", {31'b0, rd_valid}, 32'd1);
        chk("R9 read new LO", rd_data, 32'h00030000);
        chk("R9 busy released", {31'b0, busy}, 32'd0);
        m_hi = 32'h00000003; m_lo = 32'h00030000;

        // random mix
        for (int i = 0; i < 30; i++) begin
            logic [5:0]  f;
            logic [31:0] x, y;
            int sel;
            f = 6'h18 + 6'($urandom % 4);
            x = $urandom;
            sel = $urandom % 8;
            if (sel == 0)      y = 32'd0;
            else if (sel == 1) y = $urandom % 16;
            else               y = $urandom;
            arith(f, x, y, (f < DIVS) ? "R3 random" : "R4 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule